// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block maps the four shared PCI interrupt pins onto a sixteen-line ISA interrupt request vector. Each pin owns a one-byte steering register. Software reaches the registers through a small byte-wide configuration port. A steering register either switches its pin off, or names the ISA interrupt number that the pin drives.

The PCI pins are active low. Each input is inverted and sent to the line its register selects. When several pins select the same line, they are combined with a logical OR. Interrupt numbers reserved for system devices (0, 1, 2, 8 and 13 by default, set by a parameter) are never driven, even when a register selects them.

The request vector is combinational from the pins and the stored steering by default. A parameter can add an output register instead. The interrupt controller and the edge/level selection sit downstream and are not part of this block.

Top module: `irq_steer_router`

## Requirements
- R1: The steering registers sit at consecutive byte offsets from BASE_ADDR (default 0x60). Offset 0 steers pin A (pci_int_n[0]), offset 1 pin B, offset 2 pin C and offset 3 pin D.
- R2: A write keeps only bit 7 (the disable bit) and bits 3:0 (the IRQ number). That is a write mask of 0x8F, and bits 6:4 always read back as zero.
- R3: While bit 7 of a pin's register is set, that pin drives no ISA request line, whatever its input level.
- R4: While bit 7 is clear and the pin input is low, isa_irq[n] is high, where n is bits 3:0 of the register. It is low again once the input goes high.
- R5: After reset, every steering register reads 0x80 and isa_irq is all zero.
- R6: Pins steered to the same IRQ number are OR-combined. That line is high while any one of them is low.
- R7: isa_irq bits 0, 1, 2, 8 and 13 are never driven, even when a register selects them.
- R8: Read data appears on cfg_rdata in the cycle after a cycle with cfg_rd high, and is held until the next read. A read at an offset outside the four registers returns 0x00, and a write there changes no register.
- R9: A read and a write to the same register in the same cycle return the value held before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_rd | input | 1 | Read strobe, one cycle per read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| pci_int_n | input | 4 | Active-low PCI interrupt pins, A in bit 0 |
| isa_irq | output | 16 | Active-high ISA interrupt request vector |

## Verification
The assertions assume that the configuration inputs are free of X after reset, and that pci_int_n holds defined levels whenever reset is released. The bench drives every pin high from time zero and changes strobes, addresses and pin levels only on the falling clock edge. A strobe is high for exactly one cycle, so every registered result and every combinational interrupt output can be sampled just after the rising edge without a race. The sweep covers every pin against every IRQ number, with the disable bit both clear and set.

// File: rtl/irqsteer_pkg.sv
package irqsteer_pkg;

   // Default set of ISA lines that steering must never drive: 0, 1, 2, 8, 13
   localparam logic [15:0] DEF_RESERVED = 16'h2107;

   // Bits kept on a write: the disable bit plus the IRQ number field
   function automatic logic [7:0] route_keep_mask(input int dis_bit, input int irq_w);
      logic [7:0] m;
      m = '0;
      for (int i = 0; i < irq_w; i++) m[i] = 1'b1;
      m[dis_bit] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/irqsteer_regfile.sv
module irqsteer_regfile #(
   parameter int               NUM_PINS  = 4,
   parameter int               ADDR_W    = 8,
   parameter int               DATA_W    = 8,
   parameter int               IRQ_W     = 4,
   parameter int               DIS_BIT   = 7,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                addr,
   input  logic                             wr,
   input  logic                             rd,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   output logic [NUM_PINS-1:0][DATA_W-1:0]  routes
);
   import irqsteer_pkg::*;

   localparam int               PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam logic [7:0]       KEEP8     = route_keep_mask(DIS_BIT, IRQ_W);
   localparam logic [DATA_W-1:0] KEEP     = DATA_W'(KEEP8);
   localparam logic [DATA_W-1:0] RST_VAL  = DATA_W'(1) << DIS_BIT;

   logic [ADDR_W-1:0] offset;
   logic              hit;
   logic [PIN_W-1:0]  idx;

   assign offset = addr - BASE_ADDR;
   assign hit    = (offset < ADDR_W'(NUM_PINS));
   assign idx    = offset[PIN_W-1:0];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            routes[p] <= RST_VAL;
         else if (wr && hit && (idx == PIN_W'(p)))
            routes[p] <= wdata & KEEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= hit ? routes[idx] : '0;
   end

   // R8: read data only moves on a read strobe
   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));

   // R8: a write outside the window leaves every register as it was
   a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !hit) |=> $stable(routes));

endmodule

// File: rtl/irqsteer_decode.sv
module irqsteer_decode #(
   parameter int                  IRQ_COUNT = 16,
   parameter int                  DATA_W    = 8,
   parameter int                  DIS_BIT   = 7,
   parameter logic [IRQ_COUNT-1:0] RESERVED  = 16'h2107
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    route,
   input  logic                 int_n,
   output logic [IRQ_COUNT-1:0] req
);
   localparam int IRQ_W = $clog2(IRQ_COUNT);

   logic [IRQ_W-1:0] line;
   logic             active;

   assign line   = route[IRQ_W-1:0];
   assign active = !route[DIS_BIT] && !int_n;

   always_comb begin
      req = '0;
      if (active) req = (IRQ_COUNT'(1) << line) & ~RESERVED;
   end

   // R4: one pin drives at most one ISA line
   a_r4_single_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req));

endmodule

// File: rtl/irqsteer_merge.sv
module irqsteer_merge #(
   parameter int NUM_PINS  = 4,
   parameter int IRQ_COUNT = 16
) (
   input  logic [NUM_PINS-1:0][IRQ_COUNT-1:0] reqs,
   output logic [IRQ_COUNT-1:0]               merged
);
   always_comb begin
      merged = '0;
      for (int p = 0; p < NUM_PINS; p++) merged |= reqs[p];
   end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router #(
   parameter int                  NUM_PINS  = 4,
   parameter int                  IRQ_COUNT = 16,
   parameter int                  ADDR_W    = 8,
   parameter int                  DATA_W    = 8,
   parameter int                  DIS_BIT   = 7,
   parameter logic [ADDR_W-1:0]   BASE_ADDR = 8'h60,
   parameter logic [IRQ_COUNT-1:0] RESERVED  = irqsteer_pkg::DEF_RESERVED,
   parameter bit                  OUT_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic                 cfg_wr,
   input  logic                 cfg_rd,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic [DATA_W-1:0]    cfg_rdata,
   input  logic [NUM_PINS-1:0]  pci_int_n,
   output logic [IRQ_COUNT-1:0] isa_irq
);
   localparam int IRQ_W = $clog2(IRQ_COUNT);

   if (IRQ_COUNT != (1 << IRQ_W)) begin : g_chk_count
      $error("IRQ_COUNT must be a power of two");
   end
   if (DIS_BIT < IRQ_W || DIS_BIT >= DATA_W || DATA_W > 8) begin : g_chk_dis
      $error("DIS_BIT must lie above the IRQ field inside the data byte");
   end
   if (NUM_PINS < 1) begin : g_chk_pins
      $error("NUM_PINS must be at least one");
   end

   logic [NUM_PINS-1:0][DATA_W-1:0]    routes;
   logic [NUM_PINS-1:0][IRQ_COUNT-1:0] reqs;
   logic [IRQ_COUNT-1:0]               merged;
   logic [NUM_PINS-1:0]                dis_all;

   irqsteer_regfile #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .IRQ_W    (IRQ_W),
      .DIS_BIT  (DIS_BIT),
      .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (cfg_addr),
      .wr    (cfg_wr),
      .rd    (cfg_rd),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .routes(routes)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      irqsteer_decode #(
         .IRQ_COUNT(IRQ_COUNT),
         .DATA_W   (DATA_W),
         .DIS_BIT  (DIS_BIT),
         .RESERVED (RESERVED)
      ) u_dec (
         .clk  (clk),
         .rst_n(rst_n),
         .route(routes[p]),
         .int_n(pci_int_n[p]),
         .req  (reqs[p])
      );
      assign dis_all[p] = routes[p][DIS_BIT];
   end

   irqsteer_merge #(
      .NUM_PINS (NUM_PINS),
      .IRQ_COUNT(IRQ_COUNT)
   ) u_merge (
      .reqs  (reqs),
      .merged(merged)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) isa_irq <= '0;
         else        isa_irq <= merged;
      end
   end else begin : g_out_comb
      assign isa_irq = merged;
   end

   // R7: reserved lines stay quiet
   a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (isa_irq & RESERVED) == '0);

   // R3: with every pin switched off nothing is requested
   a_r3_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (&dis_all) |-> (merged == '0));

endmodule

// File: tb/sim_irq_steer_router.sv
`timescale 1ns/1ps
module sim_irq_steer_router;
   localparam logic [15:0] RES  = 16'h2107;
   localparam logic [7:0]  BASE = 8'h60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [3:0]  pci_int_n = 4'hF;
   logic [15:0] isa_irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irq_steer_router u0 (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pci_int_n(pci_int_n), .isa_irq(isa_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_rd = 1'b1;
      @(posedge clk); #1;
      d = cfg_rdata;
      @(negedge clk);
      cfg_rd = 1'b0;
   endtask

   task automatic set_pins(input logic [3:0] v);
      @(negedge clk);
      pci_int_n = v;
      @(posedge clk); #1;
   endtask

   function automatic logic [15:0] line_of(input int v);
      return RES[v] ? 16'h0 : (16'h1 << v);
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R5: reset state
      for (int p = 0; p < 4; p++) begin
         rd_reg(BASE + 8'(p), d);
         chk("R5 reset value", d, 8'h80);
      end
      set_pins(4'h0);
      chk("R5 no request after reset", isa_irq, 16'h0);
      set_pins(4'hF);

      // R2: write mask
      wr_reg(BASE, 8'hFF);
      rd_reg(BASE, d);
      chk("R2 mask all ones", d, 8'h8F);
      wr_reg(BASE, 8'h75);
      rd_reg(BASE, d);
      chk("R2 mask mid bits", d, 8'h05);
      wr_reg(BASE, 8'h80);

      // R1/R4/R7/R3: sweep every pin against every IRQ number
      for (int p = 0; p < 4; p++) begin
         for (int v = 0; v < 16; v++) begin
            wr_reg(BASE + 8'(p), 8'(v));
            set_pins(~(4'h1 << p));
            chk("R1 R4 R7 pin steered", isa_irq, line_of(v));
            set_pins(4'hF);
            chk("R4 pin released", isa_irq, 16'h0);
            wr_reg(BASE + 8'(p), 8'h80 | 8'(v));
            set_pins(~(4'h1 << p));
            chk("R3 disabled pin", isa_irq, 16'h0);
            set_pins(4'hF);
         end
         wr_reg(BASE + 8'(p), 8'h80);
      end

      // R1: distinct values read back at their own offsets
      wr_reg(BASE + 0, 8'h03);
      wr_reg(BASE + 1, 8'h05);
      wr_reg(BASE + 2, 8'h09);
      wr_reg(BASE + 3, 8'h0F);
      rd_reg(BASE + 0, d); chk("R1 offset 0", d, 8'h03);
      rd_reg(BASE + 1, d); chk("R1 offset 1", d, 8'h05);
      rd_reg(BASE + 2, d); chk("R1 offset 2", d, 8'h09);
      rd_reg(BASE + 3, d); chk("R1 offset 3", d, 8'h0F);
      set_pins(4'h0);
      chk("R1 R4 four lines at once", isa_irq, 16'h8228);
      set_pins(4'hF);

      // R6: sharing one line
      wr_reg(BASE + 0, 8'h0B);
      wr_reg(BASE + 1, 8'h0B);
      wr_reg(BASE + 2, 8'h80);
      wr_reg(BASE + 3, 8'h80);
      set_pins(4'hE); chk("R6 A alone", isa_irq, 16'h0800);
      set_pins(4'hD); chk("R6 B alone", isa_irq, 16'h0800);
      set_pins(4'hC); chk("R6 both", isa_irq, 16'h0800);
      set_pins(4'hF); chk("R6 neither", isa_irq, 16'h0000);

      // R8: unmapped offsets and read hold
      wr_reg(BASE + 4, 8'hFF);
      wr_reg(BASE - 1, 8'hFF);
      rd_reg(BASE + 4, d); chk("R8 unmapped read", d, 8'h00);
      for (int p = 0; p < 4; p++) begin
         rd_reg(BASE + 8'(p), d);
         chk("R8 unmapped write no effect", d, (p < 2) ? 8'h0B : 8'h80);
      end
      rd_reg(BASE + 1, d);
      repeat (3) @(posedge clk);
      #1 chk("R8 read data held", cfg_rdata, 8'h0B);

      // R9: read and write together
      @(negedge clk);
      cfg_addr = BASE + 2; cfg_wdata = 8'h07; cfg_wr = 1'b1; cfg_rd = 1'b1;
      @(posedge clk); #1;
      chk("R9 read returns old value", cfg_rdata, 8'h80);
      @(negedge clk);
      cfg_wr = 1'b0; cfg_rd = 1'b0;
      rd_reg(BASE + 2, d);
      chk("R9 write took effect", d, 8'h07);

      // R5: reset in mid-run restores defaults
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      rd_reg(BASE + 2, d);
      chk("R5 reset again", d, 8'h80);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule